// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into whole characters for a processor. It runs on the system clock and advances its bit timing only on a clock enable that pulses at sixteen times the bit rate. A high-to-low transition on the idle line arms a possible start bit. The line is sampled again half a bit later, and the frame is kept only if the line is still low. Data bits are then taken at the centre of each bit cell, least significant bit first, followed by an optional parity bit and one stop bit.

Each complete character moves from the shift register into a buffer register that the processor reads, and a ready flag is raised. The processor takes the character and pulses a read strobe, which lowers the flag. Parity, framing and overrun errors are sticky flags, cleared only by an explicit clear strobe. A separate output reports a break, meaning a line held low through a whole frame.

Top module: `serial_rx_core`

## Requirements
- R1: A low pulse on an idle line that has returned high by the half-bit re-check is discarded: no character is loaded, the ready flag stays low, and the next valid frame is received correctly.
- R2: Data bits are taken least significant bit first. With `cfg_len8`=1 the character has 8 bits. With `cfg_len8`=0 it has 7 bits, which appear on `rx_data[6:0]` with `rx_data[7]` at 0.
- R3: With `cfg_par_en`=1, one parity bit follows the last data bit. With `cfg_par_odd`=0 the data bits and the parity bit together must hold an even number of ones, and with `cfg_par_odd`=1 an odd number. A mismatch sets `err_parity`.
- R4: When a frame's stop bit has been sampled, the character is placed on `rx_data` and `rx_ready` goes high.
- R5: A stop bit sampled as 0 sets `err_frame`, and the character is still delivered.
- R6: A frame whose data, parity and stop samples are all 0 raises `brk_det`, together with `err_frame`. `brk_det` falls once the line is seen high again. A frame with any 1 among its data bits does not raise `brk_det`.
- R7: A character that completes while `rx_ready` is still high sets `err_overrun`, and the newer character replaces the older one on `rx_data`.
- R8: A one-cycle pulse on `rd_strobe` lowers `rx_ready` on the next cycle, unless a new character completes in that same cycle.
- R9: The error flags stay set through later frames and reads, and fall only after a pulse on `err_clr`.
- R10: After a synchronous reset, `rx_ready`, all error flags and `brk_det` are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | Clock enable at 16x the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_strobe | input | 1 | Processor has taken the buffered character |
| err_clr | input | 1 | Clears all error flags |
| rx_data | output | DATA_W | Buffered character |
| rx_ready | output | 1 | Buffer holds an unread character |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| brk_det | output | 1 | Break condition on the line |

## Verification
The bench sweeps every 8-bit value with no parity, every 7-bit value with even parity, and a stride of 8-bit values with odd parity. A receiver with a bit-order, length or alignment fault would return shifted or truncated values, and a parity polarity fault would flag good frames. Short low glitches test that the mid-bit re-check rejects them. A design that started on level alone would load a phantom character. Back-to-back unread frames, a stop bit forced low and a line held low for a whole frame test the overrun, framing and break paths. A design with non-sticky flags, no overwrite on overrun, or a break flag that never falls would show a mismatch in these cases.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s
);

  generate
    if (STAGES <= 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) line_s <= 1'b1;
        else     line_s <= line_in;
      end
    end else begin : g_chain
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], line_in};
      end
      assign line_s = pipe[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line_s,
  input  logic              len_long,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] frm_data,
  output logic              frm_par_err,
  output logic              frm_stop_bad,
  output logic              frm_all_zero
);

  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);

  rx_state_t         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bit_idx;
  logic [BW-1:0]     last_idx;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] data_view;
  logic              par_bit;
  logic              ones_seen;
  logic              armed;

  assign last_idx  = len_long ? BW'(DATA_W - 1) : BW'(DATA_W - 2);
  assign data_view = len_long ? shreg : {1'b0, shreg[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      st           <= ST_IDLE;
      cnt          <= '0;
      bit_idx      <= '0;
      shreg        <= '0;
      par_bit      <= 1'b0;
      ones_seen    <= 1'b0;
      armed        <= 1'b0;
      frm_data     <= '0;
      frm_par_err  <= 1'b0;
      frm_stop_bad <= 1'b0;
      frm_all_zero <= 1'b0;
    end else if (tick) begin
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (line_s) begin
            armed <= 1'b1;
          end else if (armed) begin
            armed <= 1'b0;
            st    <= ST_START;
          end
        end
        ST_START: begin
          if (cnt == HALF_M1) begin
            cnt       <= '0;
            bit_idx   <= '0;
            ones_seen <= 1'b0;
            st        <= line_s ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == FULL_M1) begin
            cnt       <= '0;
            shreg     <= {line_s, shreg[DATA_W-1:1]};
            ones_seen <= ones_seen | line_s;
            if (bit_idx == last_idx) st <= par_en ? ST_PAR : ST_STOP;
            else                     bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt == FULL_M1) begin
            cnt       <= '0;
            par_bit   <= line_s;
            ones_seen <= ones_seen | line_s;
            st        <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == FULL_M1) begin
            cnt          <= '0;
            done         <= 1'b1;
            frm_data     <= data_view;
            frm_par_err  <= par_en & (^data_view ^ par_bit ^ par_odd);
            frm_stop_bad <= ~line_s;
            frm_all_zero <= ~ones_seen & ~line_s;
            st           <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA) |-> (bit_idx <= last_idx)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4

endmodule

// File: rtl/srx_holding.sv
module srx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_par_err,
  input  logic              frm_stop_bad,
  input  logic              frm_all_zero,
  input  logic              line_s,
  input  logic              rd_strobe,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              brk_det
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
      brk_det     <= 1'b0;
    end else begin
      if (done) begin
        rx_data  <= frm_data;
        rx_ready <= 1'b1;
      end else if (rd_strobe) begin
        rx_ready <= 1'b0;
      end
      err_parity  <= (err_parity  & ~err_clr) | (done & frm_par_err);
      err_frame   <= (err_frame   & ~err_clr) | (done & frm_stop_bad);
      err_overrun <= (err_overrun & ~err_clr) | (done & rx_ready & ~rd_strobe);
      if (done && frm_all_zero) brk_det <= 1'b1;
      else if (line_s)          brk_det <= 1'b0;
    end
  end

  AST_LOAD_READY: assert property (@(posedge clk) disable iff (rst)
    done |=> rx_ready); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !done) |=> !rx_ready); // R8
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (done && rx_ready && !rd_strobe) |=> err_overrun); // R7
  AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_frame && !err_clr) |=> err_frame); // R9
  AST_BREAK_WITH_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_det) |-> err_frame); // R6

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_in,
  input  logic              cfg_len8,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              rd_strobe,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              brk_det
);

  logic              line_s;
  logic              done;
  logic [DATA_W-1:0] frm_data;
  logic              frm_par_err;
  logic              frm_stop_bad;
  logic              frm_all_zero;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .line_in (rx_in),
    .line_s  (line_s)
  );

  srx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .tick         (os_tick),
    .line_s       (line_s),
    .len_long     (cfg_len8),
    .par_en       (cfg_par_en),
    .par_odd      (cfg_par_odd),
    .done         (done),
    .frm_data     (frm_data),
    .frm_par_err  (frm_par_err),
    .frm_stop_bad (frm_stop_bad),
    .frm_all_zero (frm_all_zero)
  );

  srx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk          (clk),
    .rst          (rst),
    .done         (done),
    .frm_data     (frm_data),
    .frm_par_err  (frm_par_err),
    .frm_stop_bad (frm_stop_bad),
    .frm_all_zero (frm_all_zero),
    .line_s       (line_s),
    .rd_strobe    (rd_strobe),
    .err_clr      (err_clr),
    .rx_data      (rx_data),
    .rx_ready     (rx_ready),
    .err_parity   (err_parity),
    .err_frame    (err_frame),
    .err_overrun  (err_overrun),
    .brk_det      (brk_det)
  );

endmodule

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b1;
  logic       rx_in = 1'b1;
  logic       cfg_len8 = 1'b1;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       rd_strobe = 1'b0;
  logic       err_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, err_parity, err_frame, err_overrun, brk_det;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  serial_rx_core u_serial_rx_core (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_in(rx_in),
    .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rd_strobe(rd_strobe), .err_clr(err_clr), .rx_data(rx_data),
    .rx_ready(rx_ready), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .brk_det(brk_det)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rx_in = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input logic stop_v);
    int nb;
    logic [7:0] dm;
    nb = cfg_len8 ? 8 : 7;
    dm = cfg_len8 ? d : {1'b0, d[6:0]};
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (cfg_par_en) drive_bit((^dm) ^ cfg_par_odd ^ bad_par);
    drive_bit(stop_v);
    rx_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_clear();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic sweep_value(input logic [7:0] d, input string tag);
    logic [7:0] exp_d;
    exp_d = cfg_len8 ? d : {1'b0, d[6:0]};
    send_frame(d, 1'b0, 1'b1);
    chk({tag, " R4 ready"}, rx_ready, 1);
    chk({tag, " R2 data"}, rx_data, exp_d);
    chk({tag, " R3 parity"}, err_parity, 0);
    chk({tag, " R5 frame"}, err_frame, 0);
    if (d == 8'h00) chk({tag, " R6 no break"}, brk_det, 0);
    do_read();
    chk({tag, " R8 read clears"}, rx_ready, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 ready", rx_ready, 0);
    chk("R10 data", rx_data, 0);
    chk("R10 errors", {err_parity, err_frame, err_overrun}, 0);
    chk("R10 break", brk_det, 0);
    repeat (8) @(negedge clk);

    // R2 full 8-bit sweep, no parity
    cfg_len8 = 1'b1; cfg_par_en = 1'b0;
    for (int v = 0; v < 256; v++) sweep_value(v[7:0], "8N1");

    // R2 R3 7-bit even parity sweep
    cfg_len8 = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    for (int v = 0; v < 128; v++) sweep_value(v[7:0] | 8'h80, "7E1");

    // R3 8-bit odd parity strided sweep
    cfg_len8 = 1'b1; cfg_par_odd = 1'b1;
    for (int v = 0; v < 256; v += 5) sweep_value(v[7:0], "8O1");

    // R3 wrong parity flagged; R9 stays through a good frame and read
    send_frame(8'hA5, 1'b1, 1'b1);
    chk("R3 bad parity flagged", err_parity, 1);
    chk("R3 data kept", rx_data, 8'hA5);
    do_read();
    send_frame(8'h3E, 1'b0, 1'b1);
    do_read();
    chk("R9 parity sticky", err_parity, 1);
    do_clear();
    chk("R9 parity cleared", err_parity, 0);

    // R5 framing error with nonzero data, no break
    cfg_par_en = 1'b0;
    send_frame(8'h3C, 1'b0, 1'b0);
    chk("R5 frame flagged", err_frame, 1);
    chk("R5 data delivered", rx_data, 8'h3C);
    chk("R5 ready", rx_ready, 1);
    chk("R6 not break", brk_det, 0);
    do_read();
    send_frame(8'h81, 1'b0, 1'b1);
    chk("R9 frame sticky", err_frame, 1);
    do_read();
    do_clear();
    chk("R9 frame cleared", err_frame, 0);

    // R7 overrun
    send_frame(8'h11, 1'b0, 1'b1);
    chk("R7 first ready", rx_ready, 1);
    chk("R7 no overrun yet", err_overrun, 0);
    send_frame(8'h22, 1'b0, 1'b1);
    chk("R7 overrun flagged", err_overrun, 1);
    chk("R7 newest data", rx_data, 8'h22);
    chk("R7 still ready", rx_ready, 1);
    do_read();
    chk("R9 overrun sticky", err_overrun, 1);
    do_clear();
    chk("R9 overrun cleared", err_overrun, 0);

    // R1 glitch rejection
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
    rx_in = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 glitch no ready", rx_ready, 0);
    chk("R1 glitch no frame err", err_frame, 0);
    send_frame(8'h5A, 1'b0, 1'b1);
    chk("R1 after glitch data", rx_data, 8'h5A);
    chk("R1 after glitch ready", rx_ready, 1);
    do_read();

    // R6 break: line low for more than a full frame
    rx_in = 1'b0;
    repeat (12 * 16) @(negedge clk);
    chk("R6 break raised", brk_det, 1);
    chk("R6 break frame err", err_frame, 1);
    chk("R6 break data", rx_data, 8'h00);
    chk("R6 break ready", rx_ready, 1);
    rx_in = 1'b1;
    repeat (8) @(negedge clk);
    chk("R6 break released", brk_det, 0);
    do_read();
    do_clear();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule